// File: doc/BRIEF.md
# ULPI Link Transmit Sequencer

This block is the transmit half of the link side of an 8-bit ULPI bus. Upstream logic hands it one USB packet at a time as a byte stream with valid, ready and last. The first byte of each packet holds the PID. The block turns that stream into bus traffic. It first presents a transmit command that carries the PID, then the remaining bytes one by one, and then a single stop cycle. The PHY paces the transfer with nxt.

The block tracks which side owns the bus from the dir input. It releases the data lines whenever the PHY owns the bus and in every turnaround cycle. While the link owns the bus and has nothing to send, the block drives the idle command. If the PHY takes the bus back before a packet has finished, the transmission is abandoned. The block then raises a one-cycle abort flag and discards the rest of the upstream packet, so that the next packet starts clean.

Top module: `ulpi_link_tx`

## Requirements
- R1: While rst_ni is low, the block presents the following outputs: data output enable 0x00, data 0x00, stp low, s_ready_o low and abort_o low. The block treats the PHY as the bus owner coming out of reset.
- R2: A cycle is a turnaround when dir_i differs from its value in the previous clock cycle. The link owns the bus only when dir_i is low and the cycle is not a turnaround. In that case the data output enable is 0xFF. Otherwise the output enable is 0x00 and the data output is 0x00.
- R3: When the link owns the bus and has no packet in progress, it drives the idle command 0x00 with stp low.
- R4: The first bus byte of a packet is the transmit command 0x40 OR the low four bits of the PID byte. The upper four bits of the input PID byte are ignored.
- R5: Each bus byte stays in place until a link-owned cycle with nxt_i high. In that cycle s_ready_o is high, and the following byte is presented in the next cycle. A bus byte with s_valid_i low in the body of a packet is not consumed.
- R6: In the cycle after the last byte is accepted, if dir_i is still low, stp is high for exactly one cycle and the data output is 0x00.
- R7: After the stop cycle, the link drives the idle command and does not start a new packet until dir_i has been seen high.
- R8: If dir_i is high in any cycle after the transmit command was accepted, up to and including the stop cycle, abort_o is high for that one cycle and stp stays low.
- R9: After an abort in the body of a packet, every remaining input byte up to and including the one with last is accepted without regard to nxt or dir. None of these bytes reaches the bus. The next packet begins with a new transmit command.
- R10: Outside the discard phase, s_ready_o is never high in a cycle where the link does not own the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | 8 | Packet byte; the first byte of a packet is the PID |
| s_valid_i | input | 1 | Packet byte valid |
| s_last_i | input | 1 | Marks the final byte of a packet |
| s_ready_o | output | 1 | Byte accepted this cycle |
| ulpi_dir_i | input | 1 | Bus direction; high means the PHY owns the bus |
| ulpi_nxt_i | input | 1 | PHY accepts the current bus byte |
| ulpi_data_o | output | 8 | Data driven towards the PHY |
| ulpi_data_oe_o | output | 8 | Per-bit output enable of the data lines |
| ulpi_stp_o | output | 1 | Stop strobe that ends a transmission |
| abort_o | output | 1 | One-cycle pulse when a transmission is cut off |

## Verification
The hardest collision puts the acceptance of the final packet byte and the PHY's bus grab in the same cycle. If the byte were accepted, a stop cycle would follow. Because dir rises in that cycle, the sequencer must abort instead and discard that same byte on the next cycle. One stimulus phase forces this case: it raises dir exactly when the last byte is on offer with nxt held high. The reference model then requires abort_o high, s_ready_o low and stp low in that cycle, and s_ready_o high in the following cycle with no stop strobe. Random phases also let a bus grab coincide with the stop cycle and with turnarounds at the start of a packet.

// File: rtl/ulpi_tx_pkg.sv
package ulpi_tx_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PID_W   = 4;
  localparam int unsigned TAG_W   = BYTE_W - PID_W;
  localparam logic [TAG_W-1:0]  PID_CMD_TAG = 4'b0100;
  localparam logic [BYTE_W-1:0] CMD_IDLE    = '0;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_BODY,
    TX_STOP,
    TX_WAIT,
    TX_DRAIN
  } tx_state_e;

  typedef enum logic [1:0] {
    SEL_IDLE,
    SEL_CMD,
    SEL_DATA
  } bus_sel_e;
endpackage

// File: rtl/ulpi_bus_owner.sv
module ulpi_bus_owner #(
  parameter int unsigned BYTE_W = ulpi_tx_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  output logic              own_o,
  output logic [BYTE_W-1:0] oe_o
);
  logic dir_q;
  logic turn;

  // PHY owns the bus out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= 1'b1;
    else         dir_q <= dir_i;
  end

  assign turn  = dir_i ^ dir_q;
  assign own_o = ~dir_i & ~turn;
  assign oe_o  = {BYTE_W{own_o}};

  assert_no_drive_on_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dir_i) |-> (oe_o == '0));
endmodule

// File: rtl/ulpi_tx_seq.sv
module ulpi_tx_seq
  import ulpi_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      own_i,
  input  logic      dir_i,
  input  logic      valid_i,
  input  logic      last_i,
  input  logic      nxt_i,
  output logic      ready_o,
  output logic      stp_o,
  output logic      abort_o,
  output bus_sel_e  sel_o,
  output tx_state_e state_o
);
  tx_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TX_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ready_o = 1'b0;
    stp_o   = 1'b0;
    abort_o = 1'b0;
    sel_o   = SEL_IDLE;
    case (state_q)
      TX_IDLE: begin
        if (own_i && valid_i) begin
          sel_o = SEL_CMD;
          if (nxt_i) begin
            ready_o = 1'b1;
            state_d = last_i ? TX_STOP : TX_BODY;
          end
        end
      end
      TX_BODY: begin
        if (dir_i) begin
          abort_o = 1'b1;
          state_d = TX_DRAIN;
        end else begin
          sel_o = SEL_DATA;
          if (own_i && valid_i && nxt_i) begin
            ready_o = 1'b1;
            if (last_i) state_d = TX_STOP;
          end
        end
      end
      TX_STOP: begin
        if (dir_i) begin
          abort_o = 1'b1;
          state_d = TX_IDLE;
        end else if (own_i) begin
          stp_o   = 1'b1;
          state_d = TX_WAIT;
        end
      end
      TX_WAIT: begin
        if (dir_i) state_d = TX_IDLE;
      end
      TX_DRAIN: begin
        ready_o = valid_i;
        if (valid_i && last_i) state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  assign state_o = state_q;

  assert_stp_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stp_o |=> !stp_o);
  assert_abort_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  assert_abort_no_stp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !stp_o);
  assert_ready_needs_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && state_q != TX_DRAIN) |-> own_i);
  assert_wait_no_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_WAIT) |-> !ready_o);
endmodule

// File: rtl/ulpi_tx_mux.sv
module ulpi_tx_mux
  import ulpi_tx_pkg::*;
(
  input  logic              own_i,
  input  bus_sel_e          sel_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] data_o
);
  always_comb begin
    data_o = CMD_IDLE;
    if (own_i) begin
      case (sel_i)
        SEL_CMD:  data_o = {PID_CMD_TAG, byte_i[PID_W-1:0]};
        SEL_DATA: data_o = byte_i;
        default:  data_o = CMD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ulpi_link_tx.sv
module ulpi_link_tx
  import ulpi_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic              ulpi_dir_i,
  input  logic              ulpi_nxt_i,
  output logic [BYTE_W-1:0] ulpi_data_o,
  output logic [BYTE_W-1:0] ulpi_data_oe_o,
  output logic              ulpi_stp_o,
  output logic              abort_o
);
  logic      own;
  bus_sel_e  sel;
  tx_state_e state;

  ulpi_bus_owner #(.BYTE_W(BYTE_W)) u_owner (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dir_i  (ulpi_dir_i),
    .own_o  (own),
    .oe_o   (ulpi_data_oe_o)
  );

  ulpi_tx_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .own_i   (own),
    .dir_i   (ulpi_dir_i),
    .valid_i (s_valid_i),
    .last_i  (s_last_i),
    .nxt_i   (ulpi_nxt_i),
    .ready_o (s_ready_o),
    .stp_o   (ulpi_stp_o),
    .abort_o (abort_o),
    .sel_o   (sel),
    .state_o (state)
  );

  ulpi_tx_mux u_mux (
    .own_i  (own),
    .sel_i  (sel),
    .byte_i (s_data_i),
    .data_o (ulpi_data_o)
  );

  assert_stp_carries_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ulpi_stp_o |-> (ulpi_data_o == CMD_IDLE && ulpi_data_oe_o == '1));
  assert_cmd_tag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == TX_IDLE && s_valid_i && ulpi_data_oe_o == '1)
      |-> (ulpi_data_o[BYTE_W-1:PID_W] == PID_CMD_TAG));
  assert_released_bus_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ulpi_data_oe_o == '0) |-> (ulpi_data_o == '0 && !ulpi_stp_o));
endmodule

// File: tb/tb_ulpi_link_tx.sv
`timescale 1ns/1ps
module tb_ulpi_link_tx;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [7:0] s_data;
  logic       s_valid, s_last, s_ready;
  logic       dir, nxt;
  logic [7:0] ulpi_data, ulpi_oe;
  logic       stp, abort;

  always #2 clk = ~clk;

  ulpi_link_tx dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
    .ulpi_dir_i(dir), .ulpi_nxt_i(nxt),
    .ulpi_data_o(ulpi_data), .ulpi_data_oe_o(ulpi_oe),
    .ulpi_stp_o(stp), .abort_o(abort)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state: 0 idle, 1 body, 2 stop due, 3 wait for PHY, 4 discard
  byte unsigned q_byte[$];
  bit           q_last[$];
  int  phase = 0;
  bit  prev_dir = 1;
  bit  pres = 0;
  int  phy_hold = 0;
  int  n_collide = 0, n_abort = 0, n_stp = 0;

  task automatic refill();
    int len;
    if (q_byte.size() == 0) begin
      len = 1 + int'($urandom % 5);
      for (int i = 0; i < len; i++) begin
        q_byte.push_back(byte'($urandom));
        q_last.push_back(i == len - 1);
      end
    end
  endtask

  task automatic step(input int mode);
    bit own, e_ready, e_stp, e_abort, cur_last, trig;
    logic [7:0] e_data, e_oe;
    string dtag, rtag;
    @(negedge clk);
    refill();
    if (!pres && $urandom % 4 != 0) pres = 1;
    s_valid = pres;
    s_data  = pres ? q_byte[0] : 8'h00;
    s_last  = pres ? q_last[0] : 1'b0;
    cur_last = pres && q_last[0];
    nxt = (mode == 2) ? 1'b1 : (mode == 1 ? ($urandom % 4 != 0) : ($urandom % 2 == 1));
    trig = 0;
    if (phase == 3 && $urandom % 3 == 0) trig = 1;
    if (mode == 1 && $urandom % 8 == 0) trig = 1;
    if (mode == 0 && phase == 0 && $urandom % 32 == 0) trig = 1;
    if (mode == 2 && phase == 1 && cur_last) trig = 1;
    if (phy_hold > 0) begin dir = 1; phy_hold--; end
    else if (trig) begin dir = 1; phy_hold = int'($urandom % 3); end
    else dir = 0;
    #1;
    own = !dir && (dir == prev_dir);
    e_oe = own ? 8'hFF : 8'h00;
    e_data = 8'h00; e_ready = 0; e_stp = 0; e_abort = 0;
    dtag = "R3 idle"; rtag = own ? "R5 ready" : "R10 ready";
    case (phase)
      0: begin
        if (own && pres) begin
          e_data = 8'h40 | (s_data & 8'h0F); dtag = "R4 cmd";
          e_ready = nxt;
        end
      end
      1: begin
        dtag = "R5 body";
        if (dir) e_abort = 1;
        else begin
          e_data = s_data;
          e_ready = pres && nxt;
        end
        if (mode == 2 && dir && cur_last) n_collide++;
      end
      2: begin
        dtag = "R6 stop";
        if (dir) e_abort = 1; else e_stp = 1;
      end
      3: begin dtag = "R7 wait"; rtag = "R7 ready"; end
      default: begin dtag = "R9 drain"; rtag = "R9 ready"; e_ready = pres; end
    endcase
    chk("R2 oe", ulpi_oe, e_oe);
    chk(dtag, ulpi_data, e_data);
    chk("R6 stp", {7'd0, stp}, {7'd0, e_stp});
    chk(rtag, {7'd0, s_ready}, {7'd0, e_ready});
    chk("R8 abort", {7'd0, abort}, {7'd0, e_abort});
    if (e_abort) n_abort++;
    if (e_stp) n_stp++;
    // advance model to post-edge state
    case (phase)
      0: if (e_ready) phase = cur_last ? 2 : 1;
      1: if (dir) phase = 4; else if (e_ready && cur_last) phase = 2;
      2: phase = dir ? 0 : 3;
      3: if (dir) phase = 0;
      default: if (pres && cur_last) phase = 0;
    endcase
    if (e_ready) begin
      void'(q_byte.pop_front());
      void'(q_last.pop_front());
      pres = 0;
    end
    prev_dir = dir;
  endtask

  initial begin
    rst_ni = 0; dir = 1; nxt = 0; s_valid = 0; s_data = 0; s_last = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 oe", ulpi_oe, 8'h00);
    chk("R1 data", ulpi_data, 8'h00);
    chk("R1 stp", {7'd0, stp}, 8'h00);
    chk("R1 ready", {7'd0, s_ready}, 8'h00);
    chk("R1 abort", {7'd0, abort}, 8'h00);
    @(negedge clk);
    rst_ni = 1;
    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 4000; c++) step(m);
    chk("R8 collisions seen", {7'd0, n_collide > 0}, 8'h01);
    chk("R8 aborts seen", {7'd0, n_abort > 0}, 8'h01);
    chk("R6 stops seen", {7'd0, n_stp > 0}, 8'h01);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule